// File: doc/BRIEF.md
# MOESI Snooping Line-State Controller

This block keeps the coherence state of every line of a snooping cache and decides, one request per clock, what that line does next. Each line is in one of five states: Modified (only copy, memory stale), Owned (latest data, memory may be stale, other caches may hold Shared copies), Exclusive (only copy, memory current), Shared (valid copy, possibly one of several) or Invalid. Requests come from the local processor (read, write, evict) or from the bus (snooped read, snooped read-exclusive, snooped upgrade). A fill-shared input tells a read miss whether some other cache kept a copy.

For each accepted request the controller reports, one clock later, whether the line was valid, the line's new state, whether this cache must put the line on the bus for a peer (cache-to-cache supply), whether it must write the line back to memory, and which bus request it has to issue. A snooped read of a dirty line moves it to Owned and supplies the data without touching memory; the memory update is deferred until the Owned or Modified copy is evicted. Data arrays and the bus fabric sit outside this block.

Top module: `moesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 0) and resp_valid is low. State codes: Invalid 0, Shared 1, Exclusive 2, Owned 3, Modified 4. Bus codes: none 0, read 1, read-exclusive 2, upgrade 3.
- R2: A processor read (op 0) of a valid line keeps its state with no bus request; a read of an Invalid line issues a read (bus 1) and fills to Exclusive when fill_shared is low, Shared when high.
- R3: A processor write (op 1) always leaves the line Modified: from Modified or Exclusive silently, from Shared or Owned with an upgrade (bus 3), from Invalid with a read-exclusive (bus 2).
- R4: A snooped read (op 2) moves Modified to Owned and keeps Owned, both supplying the data; Exclusive becomes Shared; Shared and Invalid are unchanged; no writeback and no bus request result.
- R5: A snooped read-exclusive (op 3) or snooped upgrade (op 4) leaves the line Invalid; supply is asserted only when the line was Modified or Owned.
- R6: An evict (op 5) leaves the line Invalid and asserts writeback only when the line was Modified or Owned.
- R7: Op codes 6 and 7 change no line and cause no supply, writeback or bus request, while reporting the line's current state and hit; with req_valid low, resp_valid is low one clock later and supply, writeback and bus are all zero.
- R8: A request changes only the line at req_idx; all other lines keep their state.
- R9: In a system of several controllers that issue snoops to one another, at most one holds a given line in Modified, Exclusive or Owned, and a Modified or Exclusive holder is the only valid copy.
- R10: The response for a request registered at clock edge k appears on the outputs after edge k, with resp_hit high exactly when the line was not Invalid before the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 3 | Request code (0 read, 1 write, 2 snoop read, 3 snoop read-exclusive, 4 snoop upgrade, 5 evict, 6/7 no action) |
| req_idx | input | IDX_W | Line index |
| fill_shared | input | 1 | Another cache keeps a copy on this read miss |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Line was valid before the request |
| resp_state | output | 3 | New line state |
| resp_supply | output | 1 | Put the line on the bus for a peer |
| resp_writeback | output | 1 | Write the line to memory |
| resp_bus | output | 2 | Bus request to issue |

## Verification
The bench runs three controllers as peers, with every processor request on one turned into the matching snoop on the others, and tracks every line of every controller in its own model. It aims at the Owned corner: a dirty line read by a peer must go to Owned and supply without a writeback, and a design that wrote back there, or went to Shared, would lose the deferred memory update or leave two dirty claims. It also drives writes to Shared and Owned lines (a design that issued read-exclusive, or skipped the upgrade, leaves a stale copy in a peer), read misses with and without a shared copy (a wrong fill to Exclusive breaks single ownership), and evicts of clean lines that must stay silent. Sweeps with the no-action codes confirm that neighbouring lines were untouched.

// File: rtl/moesi_pkg.sv
package moesi_pkg;

    typedef enum logic [2:0] {
        ST_I = 3'd0,
        ST_S = 3'd1,
        ST_E = 3'd2,
        ST_O = 3'd3,
        ST_M = 3'd4
    } line_state_e;

    typedef enum logic [1:0] {
        BUS_NONE = 2'd0,
        BUS_RD   = 2'd1,
        BUS_RDX  = 2'd2,
        BUS_UPG  = 2'd3
    } bus_req_e;

    localparam logic [2:0] OP_PRD   = 3'd0;
    localparam logic [2:0] OP_PWR   = 3'd1;
    localparam logic [2:0] OP_SRD   = 3'd2;
    localparam logic [2:0] OP_SRDX  = 3'd3;
    localparam logic [2:0] OP_SUPG  = 3'd4;
    localparam logic [2:0] OP_EVICT = 3'd5;

    typedef struct packed {
        line_state_e nxt;
        logic        supply;
        logic        wb;
        bus_req_e    bus;
    } line_act_t;

    typedef struct packed {
        logic        vld;
        logic        hit;
        line_state_e st;
        logic        sup;
        logic        wb;
        bus_req_e    bus;
        logic [2:0]  op;
        line_state_e prev;
    } resp_t;

endpackage

// File: rtl/moesi_line_next.sv
module moesi_line_next
    import moesi_pkg::*;
(
    input  line_state_e cur,
    input  logic [2:0]  op,
    input  logic        shared,
    output line_act_t   act
);

    logic dirty;
    assign dirty = (cur == ST_M) || (cur == ST_O);

    always_comb begin
        act.nxt    = cur;
        act.supply = 1'b0;
        act.wb     = 1'b0;
        act.bus    = BUS_NONE;
        case (op)
            OP_PRD: begin
                if (cur == ST_I) begin
                    act.nxt = shared ? ST_S : ST_E;
                    act.bus = BUS_RD;
                end
            end
            OP_PWR: begin
                act.nxt = ST_M;
                case (cur)
                    ST_I:       act.bus = BUS_RDX;
                    ST_S, ST_O: act.bus = BUS_UPG;
                    default:    act.bus = BUS_NONE;
                endcase
            end
            OP_SRD: begin
                if (dirty) begin
                    act.nxt    = ST_O;
                    act.supply = 1'b1;
                end else if (cur == ST_E) begin
                    act.nxt = ST_S;
                end
            end
            OP_SRDX, OP_SUPG: begin
                act.nxt    = ST_I;
                act.supply = dirty;
            end
            OP_EVICT: begin
                act.nxt = ST_I;
                act.wb  = dirty;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/moesi_line_store.sv
module moesi_line_store
    import moesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = $clog2(NUM_LINES)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output line_state_e      rd_state,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  line_state_e      wr_state
);

    line_state_e lines_d [NUM_LINES];
    line_state_e lines_q [NUM_LINES];

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        always_comb begin
            lines_d[g] = lines_q[g];
            if (wr_en && (wr_idx == IDX_W'(g))) lines_d[g] = wr_state;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) lines_q[g] <= ST_I;
            else        lines_q[g] <= lines_d[g];
        end
    end

    assign rd_state = lines_q[rd_idx];

    AST_STORE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> lines_q[$past(wr_idx)] == $past(wr_state)); // R8

endmodule

// File: rtl/moesi_line_ctrl.sv
module moesi_line_ctrl
    import moesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    localparam int IDX_W = $clog2(NUM_LINES)
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [2:0]       req_op,
    input  logic [IDX_W-1:0] req_idx,
    input  logic             fill_shared,
    output logic             resp_valid,
    output logic             resp_hit,
    output logic [2:0]       resp_state,
    output logic             resp_supply,
    output logic             resp_writeback,
    output logic [1:0]       resp_bus
);

    line_state_e cur;
    line_act_t   act;
    resp_t       r_d, r_q;

    moesi_line_store #(.NUM_LINES(NUM_LINES)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .rd_state (cur),
        .wr_en    (req_valid),
        .wr_idx   (req_idx),
        .wr_state (act.nxt)
    );

    moesi_line_next u_next (
        .cur    (cur),
        .op     (req_op),
        .shared (fill_shared),
        .act    (act)
    );

    always_comb begin
        r_d     = r_q;
        r_d.vld = req_valid;
        r_d.hit = 1'b0;
        r_d.sup = 1'b0;
        r_d.wb  = 1'b0;
        r_d.bus = BUS_NONE;
        if (req_valid) begin
            r_d.hit  = (cur != ST_I);
            r_d.st   = act.nxt;
            r_d.sup  = act.supply;
            r_d.wb   = act.wb;
            r_d.bus  = act.bus;
            r_d.op   = req_op;
            r_d.prev = cur;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign resp_valid     = r_q.vld;
    assign resp_hit       = r_q.hit;
    assign resp_state     = r_q.st;
    assign resp_supply    = r_q.sup;
    assign resp_writeback = r_q.wb;
    assign resp_bus       = r_q.bus;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !resp_valid |-> !resp_supply && !resp_writeback && resp_bus == 2'd0); // R7
    AST_FILL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_bus == 2'd1 |-> resp_state == 3'd1 || resp_state == 3'd2); // R2
    AST_UPG_FROM_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_bus == 2'd3 |-> (r_q.prev == ST_S || r_q.prev == ST_O) && resp_state == 3'd4); // R3
    AST_SUPPLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        resp_supply |-> r_q.prev == ST_M || r_q.prev == ST_O); // R5
    AST_WB_ON_EVICT: assert property (@(posedge clk) disable iff (!rst_n)
        resp_writeback |-> r_q.op == OP_EVICT && resp_state == 3'd0); // R6
    AST_SNOOP_RD_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && r_q.op == OP_SRD |-> !resp_writeback && resp_bus == 2'd0); // R4
    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid); // R10

endmodule

// File: tb/moesi_line_ctrl_test.sv
`timescale 1ns/1ps
module moesi_line_ctrl_test;

    localparam int NAG  = 3;
    localparam int NL   = 4;
    localparam int IDXW = $clog2(NL);
    localparam int SI = 0, SS = 1, SE = 2, SO = 3, SM = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic            rv  [NAG];
    logic [2:0]      rop [NAG];
    logic [IDXW-1:0] rix [NAG];
    logic            rsh [NAG];
    logic            ov  [NAG];
    logic            oh  [NAG];
    logic [2:0]      ost [NAG];
    logic            osu [NAG];
    logic            owb [NAG];
    logic [1:0]      obu [NAG];

    moesi_line_ctrl #(.NUM_LINES(NL)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(rv[0]), .req_op(rop[0]),
        .req_idx(rix[0]), .fill_shared(rsh[0]), .resp_valid(ov[0]),
        .resp_hit(oh[0]), .resp_state(ost[0]), .resp_supply(osu[0]),
        .resp_writeback(owb[0]), .resp_bus(obu[0]));

    for (genvar g = 1; g < NAG; g++) begin : g_peer
        moesi_line_ctrl #(.NUM_LINES(NL)) peer (
            .clk(clk), .rst_n(rst_n), .req_valid(rv[g]), .req_op(rop[g]),
            .req_idx(rix[g]), .fill_shared(rsh[g]), .resp_valid(ov[g]),
            .resp_hit(oh[g]), .resp_state(ost[g]), .resp_supply(osu[g]),
            .resp_writeback(owb[g]), .resp_bus(obu[g]));
    end

    int vectors = 0;
    int miscompares = 0;
    int model  [NAG][NL];
    int shadow [NAG][NL];

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3, 4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic void ref_step(input int cur, input int op, input bit sh,
                                     output int nx, output int sup, output int wb, output int bus);
        bit dirty;
        dirty = (cur == SM) || (cur == SO);
        nx = cur; sup = 0; wb = 0; bus = 0;
        if (op == 0) begin
            if (cur == SI) begin nx = sh ? SS : SE; bus = 1; end
        end else if (op == 1) begin
            nx = SM;
            if (cur == SI) bus = 2;
            else if (cur == SS || cur == SO) bus = 3;
        end else if (op == 2) begin
            if (dirty) begin nx = SO; sup = 1; end
            else if (cur == SE) nx = SS;
        end else if (op == 3 || op == 4) begin
            nx = SI; sup = dirty;
        end else if (op == 5) begin
            nx = SI; wb = dirty;
        end
    endfunction

    task automatic idle_all();
        for (int a = 0; a < NAG; a++) begin
            rv[a] = 1'b0; rop[a] = 3'd7; rix[a] = '0; rsh[a] = 1'b0;
        end
    endtask

    // Apply the set-up inputs, then check every agent one clock later (R10)
    task automatic apply();
        int nx, sup, wb, bus, cur, ln;
        @(posedge clk);
        @(negedge clk);
        for (int a = 0; a < NAG; a++) begin
            if (rv[a]) begin
                ln  = int'(rix[a]);
                cur = model[a][ln];
                ref_step(cur, int'(rop[a]), rsh[a], nx, sup, wb, bus);
                check("R10", "resp_valid", int'(ov[a]), 1);
                check("R10", "hit", int'(oh[a]), int'(cur != SI));
                check(req_of(int'(rop[a])), "state", int'(ost[a]), nx);
                check(req_of(int'(rop[a])), "supply", int'(osu[a]), sup);
                check(req_of(int'(rop[a])), "writeback", int'(owb[a]), wb);
                check(req_of(int'(rop[a])), "bus", int'(obu[a]), bus);
                model[a][ln]  = nx;
                shadow[a][ln] = int'(ost[a]);
            end else begin
                check("R7", "idle resp_valid", int'(ov[a]), 0);
                check("R7", "idle quiet", int'(osu[a]) + int'(owb[a]) + int'(obu[a]), 0);
            end
        end
    endtask

    // R9: single-owner rule over states reported at the ports
    task automatic check_owners();
        for (int l = 0; l < NL; l++) begin
            int own, valid, excl;
            own = 0; valid = 0; excl = 0;
            for (int a = 0; a < NAG; a++) begin
                if (shadow[a][l] == SM || shadow[a][l] == SE || shadow[a][l] == SO) own++;
                if (shadow[a][l] == SM || shadow[a][l] == SE) excl++;
                if (shadow[a][l] != SI) valid++;
            end
            check("R9", "owner count > 1", int'(own > 1), 0);
            check("R9", "exclusive with copies", int'(excl > 0 && valid > 1), 0);
        end
    endtask

    // kind 0 read, 1 write, 2 evict; peers receive the matching snoop
    task automatic sys(input int a, input int kind, input int line);
        int cur, sop;
        bit others;
        idle_all();
        cur = model[a][line];
        others = 1'b0;
        for (int b = 0; b < NAG; b++) if (b != a && model[b][line] != SI) others = 1'b1;
        sop = -1;
        rv[a] = 1'b1; rix[a] = IDXW'(line); rsh[a] = others;
        if (kind == 0) begin
            rop[a] = 3'd0;
            if (cur == SI) sop = 2;
        end else if (kind == 1) begin
            rop[a] = 3'd1;
            if (cur == SI) sop = 3;
            else if (cur == SS || cur == SO) sop = 4;
        end else begin
            rop[a] = 3'd5;
        end
        if (sop >= 0) begin
            for (int b = 0; b < NAG; b++) if (b != a) begin
                rv[b] = 1'b1; rop[b] = 3'(sop); rix[b] = IDXW'(line); rsh[b] = 1'b0;
            end
        end
        apply();
        check_owners();
    endtask

    task automatic direct(input int a, input int op, input int line, input bit sh);
        idle_all();
        rv[a] = 1'b1; rop[a] = 3'(op); rix[a] = IDXW'(line); rsh[a] = sh;
        apply();
    endtask

    task automatic probe_all();
        for (int a = 0; a < NAG; a++)
            for (int l = 0; l < NL; l++) begin
                direct(a, 6 + (l % 2), l, 1'b1);
                check("R8", "line kept", int'(ost[a]), model[a][l]);
            end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        for (int a = 0; a < NAG; a++)
            for (int l = 0; l < NL; l++) begin model[a][l] = SI; shadow[a][l] = SI; end
        idle_all();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "resp_valid after reset", int'(ov[0]), 0);
        rst_n = 1'b1;
        // R1: every line reads back Invalid
        for (int l = 0; l < NL; l++) begin
            direct(0, 6, l, 1'b0);
            check("R1", "reset state", int'(ost[0]), SI);
            check("R1", "reset hit", int'(oh[0]), 0);
        end
        // Directed coherence story on line 0
        sys(0, 1, 0);                       // R3 I->M read-exclusive, peers invalid
        sys(1, 0, 0);                       // R4 M->O supplies, R2 fill to S
        check("R4", "owner after snoop read", int'(ost[0]), SO);
        check("R2", "shared fill", int'(ost[1]), SS);
        sys(0, 0, 0);                       // R2 hit on Owned, no bus
        sys(0, 1, 0);                       // R3 O->M upgrade, R5 S->I
        sys(2, 0, 0);                       // M->O again
        sys(1, 1, 0);                       // R3 I->M, R5 owner supplies
        sys(1, 2, 0);                       // R6 evict M writes back
        // Line 1: exclusive path
        sys(1, 0, 1);                       // R2 fill to E
        check("R2", "exclusive fill", int'(ost[1]), SE);
        sys(1, 1, 1);                       // R3 E->M silent
        check("R3", "silent bus", int'(obu[1]), 0);
        sys(2, 0, 1);                       // M->O
        sys(1, 2, 1);                       // R6 evict Owned writes back
        check("R6", "owned evict writeback", int'(owb[1]), 1);
        sys(2, 2, 1);                       // R6 evict Shared silent
        sys(0, 0, 2);                       // E
        sys(1, 0, 2);                       // R4 E->S
        sys(0, 2, 2);                       // R6 evict Shared silent
        // Direct snoops and ignored codes on uut
        direct(0, 0, 3, 1'b0);              // E
        direct(0, 7, 3, 1'b0);              // R7 no change
        check("R7", "code 7 keeps state", int'(ost[0]), SE);
        direct(0, 1, 3, 1'b0);              // M
        direct(0, 4, 3, 1'b0);              // R5 upgrade snoop on M supplies
        direct(0, 4, 3, 1'b0);              // R5 on I: nothing
        direct(0, 3, 2, 1'b0);              // R5 on I
        idle_all();
        apply();                            // R7 idle cycle
        probe_all();
        // Random system traffic
        for (int t = 0; t < 1500; t++)
            sys(int'($urandom_range(0, NAG - 1)), int'($urandom_range(0, 2)),
                int'($urandom_range(0, NL - 1)));
        probe_all();
        finish_run();
    end

endmodule